// File: doc/BRIEF.md
# Processor Sleep and Wake-up Controller

This block puts a small processor core into a low-power sleep state and brings it back out. The core raises a one-cycle strobe when it executes its sleep instruction. The controller then either halts the core or, if an interrupt is already pending, lets the instruction pass as a no-op. While the core sleeps, the controller watches three wake sources: an external reset, a watchdog timeout and the enabled interrupt sources. When one fires, it issues a one-cycle watchdog clear. It then waits for the oscillator to stabilise and releases the core. For an interrupt wake with the global interrupt enable set, it also schedules a branch to the interrupt vector.

The core has already prefetched the instruction after the sleep instruction, so that instruction runs in the first cycle after release. The global interrupt enable plays no part in deciding whether to wake. It only decides whether the core branches to the vector afterwards. The branch takes one dummy cycle, which the core discards, while it loads the vector address. Two status bits record the history for software. The power-down bit is set at power-up and cleared when sleep begins. The timeout bit is set at power-up and cleared by a watchdog wake. There is no data stream at this block's edge, so every pin is a plain control or status level.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After power-on reset (`por_n` low), `pd_bit`=1, `to_bit`=1, `core_halt`=0, `core_rst`=0, `wdt_clear`=0, `vec_req`=0 and `dummy_cycle`=0.
- R2: A `sleep_exec` strobe with no source having both its `irq_flag` and `irq_en` bit at 1 makes `core_halt` 1 from the next cycle and clears `pd_bit` at that same edge.
- R3: A `sleep_exec` strobe while any source has both its flag and its enable at 1 is a no-op: `core_halt` stays 0 and `pd_bit` keeps its value, whatever `gie` is.
- R4: While asleep, a source wakes the core only if its `irq_en` bit is 1. A flag whose enable is 0 is ignored, and `gie` has no effect on the wake decision.
- R5: A watchdog timeout wakes the core only when `wdt_en` is 1, and that wake clears `to_bit`. An interrupt wake leaves `to_bit` unchanged.
- R6: Every wake-up, from any source including the external reset, drives `wdt_clear` to 1 for exactly the one cycle after the wake edge.
- R7: After an interrupt or watchdog wake, `core_halt` stays 1 for exactly `OST_CYCLES` cycles after the wake edge and then falls to 0.
- R8: The first released cycle never redirects. If the wake came from an interrupt and `gie` is 1 in that cycle, the next cycle has `vec_req`=1, `dummy_cycle`=1 and `vec_addr`=`VEC_ADDR` (0x0004). Otherwise no redirect occurs.
- R9: `ext_rst` high while asleep wakes the core at once. In the next cycle `core_rst`=1 and `core_halt`=0, `pd_bit` stays 0 and `to_bit` is unchanged.
- R10: When wake sources coincide, the external reset wins over the watchdog, and the watchdog wins over an interrupt. A watchdog-over-interrupt wake clears `to_bit` and produces no vector redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, one tick per instruction cycle |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| sleep_exec | input | 1 | Strobe: the core executes the sleep instruction |
| ext_rst | input | 1 | External reset request |
| wdt_en | input | 1 | Watchdog enabled |
| wdt_timeout | input | 1 | Watchdog counter expired |
| gie | input | 1 | Global interrupt enable |
| irq_flag | input | NUM_SRC | Per-source interrupt flags |
| irq_en | input | NUM_SRC | Per-source interrupt enables |
| core_halt | output | 1 | Stop the core clock enable |
| core_rst | output | 1 | Device reset caused by the external reset |
| wdt_clear | output | 1 | One-cycle watchdog counter clear |
| vec_req | output | 1 | Load program counter with `vec_addr` |
| dummy_cycle | output | 1 | Discard the instruction fetched this cycle |
| vec_addr | output | VEC_W | Interrupt vector address |
| pd_bit | output | 1 | Power-down status bit |
| to_bit | output | 1 | Timeout status bit |

## Verification
The bench builds the controller with `OST_CYCLES`=6 and `NUM_SRC`=4. The short start-up wait lets each wake-to-release sequence be counted cycle by cycle, so the exact halt length and the release, dummy and vector cycles can be checked without long runs. Four sources are enough to mix masked and enabled flags in the same test. They also allow coincident wake sources in the priority checks.

// File: rtl/swc_pkg.sv
package swc_pkg;
  typedef enum logic [2:0] {
    ST_RUN,
    ST_SLEEP,
    ST_OSC_WAIT,
    ST_EXEC_NEXT,
    ST_DUMMY
  } swc_state_e;

  typedef enum logic [1:0] {
    WK_NONE,
    WK_RESET,
    WK_WDT,
    WK_IRQ
  } swc_wake_e;
endpackage

// File: rtl/swc_wake_arb.sv
module swc_wake_arb
  import swc_pkg::*;
#(
  parameter int NUM_SRC = 4
) (
  input  logic               ext_rst,
  input  logic               wdt_en,
  input  logic               wdt_timeout,
  input  logic [NUM_SRC-1:0] irq_flag,
  input  logic [NUM_SRC-1:0] irq_en,
  output logic               irq_pending,
  output swc_wake_e          wake_src
);
  logic [NUM_SRC-1:0] armed;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign armed[g] = irq_flag[g] & irq_en[g];
  end

  assign irq_pending = |armed;

  always_comb begin
    if (ext_rst)                   wake_src = WK_RESET;
    else if (wdt_en && wdt_timeout) wake_src = WK_WDT;
    else if (irq_pending)          wake_src = WK_IRQ;
    else                           wake_src = WK_NONE;
  end
endmodule

// File: rtl/swc_ost_timer.sv
module swc_ost_timer #(
  parameter int OST_CYCLES = 1024
) (
  input  logic clk,
  input  logic por_n,
  input  logic load,
  input  logic active,
  output logic done
);
  localparam int CW = (OST_CYCLES > 1) ? $clog2(OST_CYCLES) : 1;
  localparam logic [CW-1:0] LOAD_VAL = CW'(OST_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                     cnt_q <= '0;
    else if (load)                  cnt_q <= LOAD_VAL;
    else if (active && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign done = active && (cnt_q == '0);

  assert_ost_countdown_R7: assert property (@(posedge clk) disable iff (!por_n)
    (active && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/swc_status.sv
module swc_status (
  input  logic clk,
  input  logic por_n,
  input  logic sleep_enter,
  input  logic wdt_wake,
  output logic pd_bit,
  output logic to_bit
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pd_bit <= 1'b1;
      to_bit <= 1'b1;
    end else begin
      if (sleep_enter) pd_bit <= 1'b0;
      if (wdt_wake)    to_bit <= 1'b0;
    end
  end

  assert_pd_clear_R2: assert property (@(posedge clk) disable iff (!por_n)
    sleep_enter |=> !pd_bit);
  assert_to_clear_R5: assert property (@(posedge clk) disable iff (!por_n)
    wdt_wake |=> !to_bit);
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
  import swc_pkg::*;
#(
  parameter int              NUM_SRC    = 4,
  parameter int              OST_CYCLES = 1024,
  parameter int              VEC_W      = 13,
  parameter logic [VEC_W-1:0] VEC_ADDR  = 13'h0004
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               sleep_exec,
  input  logic               ext_rst,
  input  logic               wdt_en,
  input  logic               wdt_timeout,
  input  logic               gie,
  input  logic [NUM_SRC-1:0] irq_flag,
  input  logic [NUM_SRC-1:0] irq_en,
  output logic               core_halt,
  output logic               core_rst,
  output logic               wdt_clear,
  output logic               vec_req,
  output logic               dummy_cycle,
  output logic [VEC_W-1:0]   vec_addr,
  output logic               pd_bit,
  output logic               to_bit
);
  swc_state_e state_q, state_d;
  swc_wake_e  wake_src;
  logic       irq_pending, ost_done;
  logic       sleep_enter, wake_evt;
  logic       irq_wake_q, wdt_clear_q, core_rst_q;

  swc_wake_arb #(.NUM_SRC(NUM_SRC)) u_arb (
    .ext_rst     (ext_rst),
    .wdt_en      (wdt_en),
    .wdt_timeout (wdt_timeout),
    .irq_flag    (irq_flag),
    .irq_en      (irq_en),
    .irq_pending (irq_pending),
    .wake_src    (wake_src)
  );

  swc_ost_timer #(.OST_CYCLES(OST_CYCLES)) u_ost (
    .clk    (clk),
    .por_n  (por_n),
    .load   (wake_evt && wake_src != WK_RESET),
    .active (state_q == ST_OSC_WAIT),
    .done   (ost_done)
  );

  swc_status u_status (
    .clk         (clk),
    .por_n       (por_n),
    .sleep_enter (sleep_enter),
    .wdt_wake    (wake_evt && wake_src == WK_WDT),
    .pd_bit      (pd_bit),
    .to_bit      (to_bit)
  );

  always_comb begin
    state_d     = state_q;
    sleep_enter = 1'b0;
    wake_evt    = 1'b0;
    case (state_q)
      ST_RUN: begin
        if (sleep_exec && !irq_pending) begin
          state_d     = ST_SLEEP;
          sleep_enter = 1'b1;
        end
      end
      ST_SLEEP: begin
        if (wake_src != WK_NONE) begin
          wake_evt = 1'b1;
          state_d  = (wake_src == WK_RESET) ? ST_RUN : ST_OSC_WAIT;
        end
      end
      ST_OSC_WAIT:  if (ost_done) state_d = ST_EXEC_NEXT;
      ST_EXEC_NEXT: state_d = (gie && irq_wake_q) ? ST_DUMMY : ST_RUN;
      ST_DUMMY:     state_d = ST_RUN;
      default:      state_d = ST_RUN;
    endcase
    if (ext_rst && state_q != ST_SLEEP) begin
      state_d     = ST_RUN;
      sleep_enter = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state_q     <= ST_RUN;
      irq_wake_q  <= 1'b0;
      wdt_clear_q <= 1'b0;
      core_rst_q  <= 1'b0;
    end else begin
      state_q     <= state_d;
      wdt_clear_q <= wake_evt;
      core_rst_q  <= ext_rst;
      if (wake_evt) irq_wake_q <= (wake_src == WK_IRQ);
    end
  end

  assign core_halt   = (state_q == ST_SLEEP) || (state_q == ST_OSC_WAIT);
  assign core_rst    = core_rst_q;
  assign wdt_clear   = wdt_clear_q;
  assign vec_req     = (state_q == ST_DUMMY);
  assign dummy_cycle = (state_q == ST_DUMMY);
  assign vec_addr    = VEC_ADDR;

  assert_nop_when_pending_R3: assert property (@(posedge clk) disable iff (!por_n)
    (state_q == ST_RUN && sleep_exec && irq_pending) |=> !core_halt);
  assert_wdt_clear_single_R6: assert property (@(posedge clk) disable iff (!por_n)
    wdt_clear |=> !wdt_clear);
  assert_vector_after_exec_R8: assert property (@(posedge clk) disable iff (!por_n)
    vec_req |-> ($past(state_q) == ST_EXEC_NEXT));
  assert_to_kept_on_irq_R5: assert property (@(posedge clk) disable iff (!por_n)
    (wake_evt && wake_src == WK_IRQ) |=> $stable(to_bit));
  assert_reset_releases_R9: assert property (@(posedge clk) disable iff (!por_n)
    ext_rst |=> (core_rst && !core_halt));
endmodule

// File: tb/sleep_wake_ctrl_bench.sv
module sleep_wake_ctrl_bench;
  localparam int NS  = 4;
  localparam int OST = 6;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic sleep_exec = 0, ext_rst = 0, wdt_en = 0, wdt_timeout = 0, gie = 0;
  logic [NS-1:0] irq_flag = '0, irq_en = '0;
  logic core_halt, core_rst, wdt_clear, vec_req, dummy_cycle, pd_bit, to_bit;
  logic [12:0] vec_addr;

  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sleep_wake_ctrl #(.NUM_SRC(NS), .OST_CYCLES(OST)) u_sleep_wake_ctrl (
    .clk(clk), .por_n(por_n), .sleep_exec(sleep_exec), .ext_rst(ext_rst),
    .wdt_en(wdt_en), .wdt_timeout(wdt_timeout), .gie(gie),
    .irq_flag(irq_flag), .irq_en(irq_en), .core_halt(core_halt),
    .core_rst(core_rst), .wdt_clear(wdt_clear), .vec_req(vec_req),
    .dummy_cycle(dummy_cycle), .vec_addr(vec_addr), .pd_bit(pd_bit),
    .to_bit(to_bit));

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    por_n = 0; sleep_exec = 0; ext_rst = 0; wdt_en = 0; wdt_timeout = 0;
    gie = 0; irq_flag = '0; irq_en = '0;
    tick();
    por_n = 1;
    tick();
  endtask

  task automatic go_sleep();
    sleep_exec = 1;
    tick();
    sleep_exec = 0;
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R1", "pd", pd_bit, 1); chk("R1", "to", to_bit, 1);
    chk("R1", "halt", core_halt, 0); chk("R1", "core_rst", core_rst, 0);
    chk("R1", "wdt_clear", wdt_clear, 0); chk("R1", "vec_req", vec_req, 0);
    chk("R1", "dummy", dummy_cycle, 0);
  endtask

  task automatic t_nop_pending(input logic g);
    do_reset();
    gie = g; irq_flag = 4'b0100; irq_en = 4'b0110;
    go_sleep();
    chk("R3", "halt on pending", core_halt, 0);
    chk("R3", "pd kept", pd_bit, 1);
    tick();
    chk("R3", "still running", core_halt, 0);
  endtask

  // interrupt wake, full sequence; expect_vec when gie set
  task automatic t_irq_wake(input logic g);
    int halt_cnt;
    do_reset();
    irq_en = 4'b1000;
    go_sleep();
    chk("R2", "halt after sleep", core_halt, 1);
    chk("R2", "pd cleared", pd_bit, 0);
    tick();
    chk("R2", "halt held", core_halt, 1);
    gie = g; irq_flag = 4'b1000;
    tick();
    irq_flag = '0;
    chk("R6", "wdt_clear after irq wake", wdt_clear, 1);
    chk("R5", "to kept on irq wake", to_bit, 1);
    halt_cnt = 0;
    for (int i = 0; i < OST + 3 && core_halt; i++) begin
      halt_cnt++;
      if (i == 1) chk("R6", "wdt_clear one cycle", wdt_clear, 0);
      tick();
    end
    chk("R7", "startup wait length", halt_cnt, OST);
    chk("R8", "no redirect in first released cycle", vec_req, 0);
    tick();
    chk("R8", "vec_req", vec_req, g);
    chk("R8", "dummy", dummy_cycle, g);
    if (g) chk("R8", "vec_addr", vec_addr, 32'h4);
    chk("R8", "not halted", core_halt, 0);
    tick();
    chk("R8", "redirect done", vec_req, 0);
  endtask

  task automatic t_masked_ignored();
    do_reset();
    gie = 1; wdt_en = 0; irq_en = 4'b0001;
    go_sleep();
    irq_flag = 4'b0110; wdt_timeout = 1;
    repeat (3) tick();
    chk("R4", "masked flag ignored", core_halt, 1);
    chk("R5", "disabled wdt ignored", wdt_clear, 0);
    chk("R5", "to kept", to_bit, 1);
    irq_flag = '0; wdt_timeout = 0; gie = 0; irq_en = 4'b0001; irq_flag = 4'b0001;
    tick();
    irq_flag = '0;
    chk("R4", "wake with gie clear", wdt_clear, 1);
  endtask

  task automatic t_wdt_wake();
    do_reset();
    wdt_en = 1; gie = 1;
    go_sleep();
    wdt_timeout = 1;
    tick();
    wdt_timeout = 0;
    chk("R5", "to cleared", to_bit, 0);
    chk("R6", "wdt_clear on wdt wake", wdt_clear, 1);
    repeat (OST) tick();
    chk("R7", "released", core_halt, 0);
    tick();
    chk("R8", "no vector on wdt wake", vec_req, 0);
  endtask

  task automatic t_ext_reset();
    do_reset();
    wdt_en = 1;
    go_sleep();
    ext_rst = 1; wdt_timeout = 1; irq_en = 4'b0010; irq_flag = 4'b0010;
    tick();
    ext_rst = 0; wdt_timeout = 0; irq_flag = '0;
    chk("R9", "core_rst", core_rst, 1);
    chk("R9", "halt dropped", core_halt, 0);
    chk("R9", "pd stays 0", pd_bit, 0);
    chk("R10", "reset beats wdt: to kept", to_bit, 1);
    chk("R6", "wdt_clear on reset wake", wdt_clear, 1);
  endtask

  task automatic t_wdt_over_irq();
    int halt_cnt;
    do_reset();
    wdt_en = 1; gie = 1; irq_en = 4'b0100;
    go_sleep();
    wdt_timeout = 1; irq_flag = 4'b0100;
    tick();
    wdt_timeout = 0; irq_flag = '0;
    chk("R10", "wdt wins: to cleared", to_bit, 0);
    halt_cnt = 0;
    for (int i = 0; i < OST + 3 && core_halt; i++) begin halt_cnt++; tick(); end
    chk("R7", "wait length after wdt", halt_cnt, OST);
    tick();
    chk("R10", "no vector when wdt wins", vec_req, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_nop_pending(1'b0);
    t_nop_pending(1'b1);
    t_irq_wake(1'b1);
    t_irq_wake(1'b0);
    t_masked_ignored();
    t_wdt_wake();
    t_ext_reset();
    t_wdt_over_irq();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule